// File: doc/BRIEF.md
# Period-Measuring Digital Clock Multiplier

This block derives 2x, 4x and 8x rate timing from a slow external reference clock while running entirely on one constant, fast system clock. The reference passes through a synchronizer, and a rising-edge detector drives a counter that measures the reference period in system-clock cycles. Once two consecutive measurements agree, the block reports lock. From then on, one phase accumulator per rate spreads N one-cycle enable strobes evenly across every reference cycle. The first strobe is aligned to the reference edge, and the spacing between strobes never differs by more than one system-clock cycle.

Each strobe has a square-wave companion for logic that wants a level instead of an enable. A second mode gives up even spreading. In that mode each reference edge starts a burst of N strobes at a fixed spacing in system-clock cycles, whatever the reference rate. This suits downstream logic that only needs N events per reference cycle and does not care where they fall.

If the reference stops, or its period is too long for the counter, lock drops and every output goes quiet.

Top module: `clkmul_top`

## Requirements
- R1: The reference is taken through a two-stage synchronizer. If the reference is first sampled high at system-clock edge k, the aligned strobe of every active output is high during the cycle that follows edge k+2.
- R2: While locked, `period_o` equals the number of system-clock cycles between consecutive reference rising edges.
- R3: After reset, the first reference edge only starts counting. The second edge stores a measurement. Lock rises at the third edge if the new measurement is within one count of the stored one. At every later edge, lock is recomputed in the same way.
- R4: In spread mode (`mode_i` = 0), while locked and with period P >= N, output N gives exactly N strobes per reference cycle. Strobe j (j = 0..N-1) falls ceil(j*P/N) cycles after the aligned strobe. Bit 0 of `strb_o` is the 2x rate, bit 1 the 4x rate and bit 2 the 8x rate.
- R5: In spread mode with P >= 2N, every rising edge of square output N falls in a cycle where strobe N is high, and every strobe N falls on such a rising edge.
- R6: If P < N, strobe N and square N stay low, while the other outputs keep running.
- R7: In burst mode (`mode_i` = 1), while locked, output N gives N strobes spaced BURST_SPACE cycles apart, starting with the aligned strobe. All square outputs stay low in this mode.
- R8: If no reference edge arrives, lock falls MAX+1 cycles after the aligned cycle of the last edge, where MAX = 2^CNT_W - 1.
- R9: An edge that arrives while the counter sits at MAX (a period above MAX) produces no measurement and clears lock. A steady period of MAX+1 therefore never locks, while a period of MAX does lock.
- R10: After reset, and whenever lock is low, all strobes, all squares and lock read 0, and `period_o` reads 0 straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Constant fast system clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Slow reference clock, asynchronous to clk_i |
| mode_i | input | 1 | 0 = evenly spread strobes, 1 = burst after each edge |
| strb_o | output | 3 | One-cycle enables at 2x, 4x and 8x (bits 0, 1, 2) |
| sq_o | output | 3 | Square-wave companions of the strobes |
| period_o | output | CNT_W (12) | Latest measured reference period in system cycles |
| lock_o | output | 1 | Measurement stable and outputs active |

## Verification
Two of the block's functions can fall in the same cycle. The first is a reference edge, which both resynchronizes the accumulators and closes a measurement. The second is counter saturation, which declares the reference lost. They collide when the reference period is exactly MAX+1: the edge then arrives in the very cycle the counter reaches its ceiling. The bench drives such a train and expects lock and all outputs to stay low throughout. It contrasts this with a period of MAX, which must lock with a correct strobe pattern. A separate run stops the reference after lock, checks the exact cycle in which lock falls, and checks that the strobe pattern keeps its period until that cycle.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;

    typedef enum logic {
        MODE_SPREAD = 1'b0,
        MODE_BURST  = 1'b1
    } mode_e;

    typedef struct packed {
        logic strb;
        logic sq;
    } tick_t;

    // multiplication factor for rate slot idx: 2, 4, 8, ...
    function automatic int rate_of(input int idx);
        return 2 << idx;
    endfunction

endpackage

// File: rtl/clkmul_ref_sync.sv
module clkmul_ref_sync (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ref_i,
    output logic rise_o
);
    // [0] and [1] form the synchronizer, [2] holds the previous sample
    logic [2:0] shift_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) shift_q <= '0;
        else       shift_q <= {shift_q[1:0], ref_i};
    end

    assign rise_o = shift_q[1] & ~shift_q[2];

    // R1
    single_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/clkmul_period_meter.sv
module clkmul_period_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rise_i,
    output logic [CNT_W-1:0] period_o,
    output logic             lock_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, period_q, meas;
    logic             armed_q, have_q, lock_q, close;

    always_comb begin
        meas  = cnt_q + ONE;
        close = (meas == period_q) || (meas == period_q + ONE) ||
                (meas + ONE == period_q);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q    <= '0;
            period_q <= '0;
            armed_q  <= 1'b0;
            have_q   <= 1'b0;
            lock_q   <= 1'b0;
        end else if (rise_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            if (cnt_q == CNT_MAX) begin
                have_q <= 1'b0;
                lock_q <= 1'b0;
            end else if (armed_q) begin
                period_q <= meas;
                have_q   <= 1'b1;
                lock_q   <= have_q && close;
            end
        end else if (cnt_q == CNT_MAX) begin
            armed_q <= 1'b0;
            have_q  <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign period_o = period_q;
    assign lock_o   = lock_q;

    // R3
    lock_on_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> $past(rise_i));

    // R8
    stall_unlock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q == CNT_MAX && !rise_i) |=> !lock_o);

endmodule

// File: rtl/clkmul_rate_gen.sv
module clkmul_rate_gen
    import clkmul_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int RATE        = 2,
    parameter int BURST_SPACE = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rise_i,
    input  logic             lock_i,
    input  mode_e            mode_i,
    input  logic [CNT_W-1:0] period_i,
    output tick_t            tick_o
);
    localparam int ACC_W = CNT_W + 1;
    localparam int GAP_W = (BURST_SPACE > 1) ? $clog2(BURST_SPACE) : 1;
    localparam int REM_W = $clog2(RATE);
    localparam logic [ACC_W-1:0] STEP    = ACC_W'(RATE);
    localparam logic [GAP_W-1:0] GAP_RLD = GAP_W'(BURST_SPACE - 1);
    localparam logic [REM_W-1:0] REM_RLD = REM_W'(RATE - 1);

    logic [ACC_W-1:0] acc_q, sum, nxt, per_ext, half;
    logic             wrap, supported;
    logic             spr_q, sq_q, bst_q;
    logic [REM_W-1:0] brem_q;
    logic [GAP_W-1:0] bgap_q;

    always_comb begin
        per_ext   = {1'b0, period_i};
        half      = per_ext >> 1;
        sum       = acc_q + STEP;
        wrap      = sum >= per_ext;
        nxt       = wrap ? sum - per_ext : sum;
        supported = per_ext >= STEP;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q  <= '0;
            spr_q  <= 1'b0;
            sq_q   <= 1'b0;
            bst_q  <= 1'b0;
            brem_q <= '0;
            bgap_q <= '0;
        end else if (rise_i) begin
            acc_q  <= '0;
            spr_q  <= 1'b1;
            sq_q   <= 1'b1;
            bst_q  <= 1'b1;
            brem_q <= REM_RLD;
            bgap_q <= GAP_RLD;
        end else begin
            acc_q <= nxt;
            spr_q <= wrap;
            sq_q  <= nxt < half;
            if (brem_q != '0 && bgap_q == '0) begin
                bst_q  <= 1'b1;
                brem_q <= brem_q - 1'b1;
                bgap_q <= GAP_RLD;
            end else begin
                bst_q <= 1'b0;
                if (brem_q != '0) bgap_q <= bgap_q - 1'b1;
            end
        end
    end

    logic en_spread, en_burst;
    assign en_spread   = lock_i && supported && (mode_i == MODE_SPREAD);
    assign en_burst    = lock_i && (mode_i == MODE_BURST);
    assign tick_o.strb = (en_spread & spr_q) | (en_burst & bst_q);
    assign tick_o.sq   = en_spread & sq_q;

    // R4
    spread_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_i |=> spr_q);

    // R4
    acc_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lock_i && supported) |-> (acc_q < per_ext));

    generate
        if (BURST_SPACE > 1) begin : g_gap
            // R7
            burst_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                (bst_q && !rise_i) |=> !bst_q);
        end
    endgenerate

endmodule

// File: rtl/clkmul_top.sv
module clkmul_top
    import clkmul_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int NUM_RATES   = 3,
    parameter int BURST_SPACE = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 ref_i,
    input  logic                 mode_i,
    output logic [NUM_RATES-1:0] strb_o,
    output logic [NUM_RATES-1:0] sq_o,
    output logic [CNT_W-1:0]     period_o,
    output logic                 lock_o
);
    logic  rise;
    tick_t ticks [NUM_RATES];

    clkmul_ref_sync u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ref_i  (ref_i),
        .rise_o (rise)
    );

    clkmul_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .rise_i   (rise),
        .period_o (period_o),
        .lock_o   (lock_o)
    );

    generate
        for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
            clkmul_rate_gen #(
                .CNT_W       (CNT_W),
                .RATE        (rate_of(g)),
                .BURST_SPACE (BURST_SPACE)
            ) u_gen (
                .clk_i    (clk_i),
                .rst_i    (rst_i),
                .rise_i   (rise),
                .lock_i   (lock_o),
                .mode_i   (mode_e'(mode_i)),
                .period_i (period_o),
                .tick_o   (ticks[g])
            );
            assign strb_o[g] = ticks[g].strb;
            assign sq_o[g]   = ticks[g].sq;

            // R6
            narrow_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                (!mode_i && period_o < CNT_W'(rate_of(g))) |-> (!strb_o[g] && !sq_o[g]));
        end
    endgenerate

    // R10
    quiet_unlocked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !lock_o |-> (strb_o == '0 && sq_o == '0));

endmodule

// File: tb/sim_clkmul_top.sv
module sim_clkmul_top;
    localparam int W   = 12;
    localparam int MAX = (1 << W) - 1;
    localparam int SP  = 2;

    logic       clk = 1'b0, rst = 1'b1, ref_i = 1'b0, mode = 1'b0;
    logic [2:0] strb, sq;
    logic [W-1:0] period;
    logic       lock;

    always #5 clk = ~clk;

    clkmul_top #(.CNT_W(W), .NUM_RATES(3), .BURST_SPACE(SP)) u0 (
        .clk_i(clk), .rst_i(rst), .ref_i(ref_i), .mode_i(mode),
        .strb_o(strb), .sq_o(sq), .period_o(period), .lock_o(lock)
    );

    int n_run = 0, n_fail = 0, cyc = 0;
    int last_r, prev_r, n_r, cur_p;
    logic [2:0] sq_prev;
    bit done = 0;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d, P=%0d)", req, act, exp, cyc, cur_p);
        end
    endtask

    function automatic bit spread_hit(input int d, input int p, input int n);
        for (int j = 0; j < n; j++) if (d == (j * p + n - 1) / n) return 1'b1;
        return 1'b0;
    endfunction

    task automatic sample_and_check();
        int a, ne, dd;
        bit lk;
        if (cyc >= last_r + 3) begin a = last_r + 3; ne = n_r;     end
        else                   begin a = prev_r + 3; ne = n_r - 1; end
        dd = cyc - a;
        lk = (ne >= 3) && (cur_p <= MAX) && (dd <= MAX);
        check("R3/R8/R9 lock", lock, lk);
        if (lk) check("R2 period", period, cur_p);
        for (int g = 0; g < 3; g++) begin
            int n;
            bit es;
            n = 2 << g;
            if (!lk)      es = 0;
            else if (mode) es = (dd < n * SP) && (dd % SP == 0);             // R7
            else           es = (cur_p >= n) && spread_hit(dd % cur_p, cur_p, n); // R1 R4 R6
            check(mode ? "R7 burst strobe" : "R4/R6 spread strobe", strb[g], es);
            if (!lk || mode || cur_p < n)
                check("R6/R7/R10 square quiet", sq[g], 0);
            else if (cur_p >= 2 * n)
                check("R5 square rise", sq[g] & ~sq_prev[g], strb[g]);
        end
        sq_prev = sq;
    endtask

    task automatic step(input logic v);
        @(negedge clk);
        cyc++;
        sample_and_check();
        if (v && !ref_i) begin prev_r = last_r; last_r = cyc; n_r++; end
        ref_i = v;
    endtask

    task automatic restart(input logic m);
        rst = 1'b1; mode = m; ref_i = 1'b0;
        repeat (3) @(negedge clk);
        cyc += 3;
        // R10 reset state
        check("R10 reset strobes", strb, 0);
        check("R10 reset squares", sq, 0);
        check("R10 reset lock", lock, 0);
        check("R10 reset period", period, 0);
        last_r = -100000; prev_r = -100000; n_r = 0; sq_prev = '0;
        rst = 1'b0;
    endtask

    task automatic run(input int p, input int nref, input logic m, input int idle);
        restart(m);
        cur_p = p;
        for (int r = 0; r < nref; r++)
            for (int t = 0; t < p; t++) step(t < (p + 1) / 2);
        for (int i = 0; i < idle; i++) step(1'b0);
    endtask

    initial begin
        cur_p = 1;
        void'($urandom(32'd4242));
        run(3,  8, 1'b0, 0);            // R6: only 2x active
        run(6,  8, 1'b0, 0);            // R6: 8x unsupported
        run(16, 6, 1'b0, 0);            // R4 R5 exact fit for 8x
        run(37, 6, 1'b0, 0);            // R4 uneven spacing
        run(24, 6, 1'b1, 0);            // R7 burst
        run(20, 6, 1'b0, MAX + 20);     // R8 stall
        run(MAX, 4, 1'b0, 0);           // R9 longest lockable period
        run(MAX + 1, 4, 1'b0, 0);       // R9 edge meets saturation
        for (int k = 0; k < 8; k++) begin
            int p;
            p = 16 + int'($urandom % 385);
            run(p, 6, logic'($urandom % 2), 0);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule